// File: doc/BRIEF.md
# Serial Exception and Interrupt Controller

This block is the trap controller of an area-minimised processor core. It watches a set of exception request lines and an external interrupt line. When one of them is taken, it records the program counter of the faulting instruction and a code that names the cause. It saves the interrupt-enable bit and then clears it. One cycle later it raises a redirect strobe that steers instruction fetch to a fixed handler address. A return-from-exception input restores the saved interrupt-enable bit.

The four control registers (status, cause, exception PC and faulting address) are plain shift registers. Software reaches them through the data-memory path. The core selects a register and shifts it one bit per cycle, least significant bit first. On a read the bit that leaves is fed back in, so the register ends up unchanged. On a write the new bits enter at the top. Parameters set the word width and the handler address, and they remove each exception source on its own. When address errors are removed, the faulting-address register is not built and reads as zero.

Top module: `trap_ctrl_serial`

## Requirements
- R1: After reset, every control register reads as zero and `redirect_o` is low.
- R2: `reg_sel` picks the register: 0 status, 1 cause, 2 exception PC, 3 faulting address. Each cycle with `shift_en` high, the selected register shifts right by one and `rd_bit_o` shows its bit 0. With `wr_en` low, bit 0 re-enters at the top. With `wr_en` high on status or exception PC, `wr_bit` enters at the top instead. After W such cycles, the register holds its old value (read) or the W bits that were written (write).
- R3: Cause and faulting address are read-only: a write shift sequence leaves them unchanged.
- R4: A taken exception raises `redirect_o` in the next cycle, for one cycle only, and `vector_o` equals the handler address (0x00000080 by default).
- R5: A taken exception loads the exception PC with the `pc_i` of the request cycle.
- R6: A taken exception writes the cause register with the code in bits 6:2 and zeros elsewhere. The codes are: interrupt 0, address error on load 4, address error on store 5, reserved instruction 10, coprocessor unusable 11, overflow 12.
- R7: When several requests arrive in one cycle, the winner is chosen in this order: address error on load, address error on store, reserved instruction, coprocessor unusable, overflow, interrupt.
- R8: Status bit 0 is the interrupt enable and bit 1 the saved enable. A taken exception copies bit 0 into bit 1 and clears bit 0, leaving the higher bits unchanged.
- R9: `irq` is taken only while status bit 0 is set. Otherwise it has no effect on any register or on `redirect_o`.
- R10: `rfe_i` copies status bit 1 into bit 0 and leaves bit 1 unchanged.
- R11: An address error loads the faulting-address register with `badaddr_i`. Other exceptions leave it unchanged.
- R12: A capture wins over anything else in the same cycle. If an exception is taken in a cycle where the register is being shifted, or where `rfe_i` is high, the register takes the captured value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_adel | input | 1 | Address error on load |
| req_ades | input | 1 | Address error on store |
| req_resv | input | 1 | Reserved instruction |
| req_cpu | input | 1 | Coprocessor unusable |
| req_ovf | input | 1 | Arithmetic overflow |
| irq | input | 1 | External interrupt, level |
| rfe_i | input | 1 | Return from exception |
| pc_i | input | W | PC of the current instruction |
| badaddr_i | input | W | Address that faulted |
| reg_sel | input | 2 | Register select for serial access |
| shift_en | input | 1 | Shift the selected register by one bit |
| wr_en | input | 1 | Shift in `wr_bit` instead of rotating |
| wr_bit | input | 1 | Serial write data |
| rd_bit_o | output | 1 | Serial read data (bit 0 of the selected register) |
| redirect_o | output | 1 | One-cycle fetch redirect strobe |
| vector_o | output | W | Handler address |

## Verification
A capture can land in the middle of a serial access, because the core may shift the exception PC in the very cycle a new fault arrives. The bench starts a read of the exception PC, shifts it part of the way, and then raises an overflow request while `shift_en` stays high. After that it reads the register again from the start and expects exactly the PC of the request cycle. The same collision is provoked between a capture and `rfe_i`. In that case the status register must show the capture's result, with the enable cleared and saved.

// File: rtl/trap_pkg.sv
package trap_pkg;
   typedef enum logic [1:0] {
      SEL_STATUS  = 2'd0,
      SEL_CAUSE   = 2'd1,
      SEL_EPC     = 2'd2,
      SEL_BADADDR = 2'd3
   } reg_sel_e;

   localparam logic [4:0] CODE_INT  = 5'd0;
   localparam logic [4:0] CODE_ADEL = 5'd4;
   localparam logic [4:0] CODE_ADES = 5'd5;
   localparam logic [4:0] CODE_RI   = 5'd10;
   localparam logic [4:0] CODE_CPU  = 5'd11;
   localparam logic [4:0] CODE_OV   = 5'd12;

   localparam int CODE_LSB = 2;
   localparam int CODE_W   = 5;
endpackage

// File: rtl/trap_sreg.sv
// Serial control register: parallel capture has priority over shifting.
module trap_sreg #(
   parameter int W        = 32,
   parameter bit WRITABLE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_en,
   input  logic [W-1:0] load_val,
   input  logic         shift_en,
   input  logic         wr_en,
   input  logic         wr_bit,
   output logic [W-1:0] q
);
   logic top_bit;

   generate
      if (WRITABLE) begin : g_wr
         assign top_bit = wr_en ? wr_bit : q[0];
      end else begin : g_ro
         assign top_bit = q[0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         q <= '0;
      else if (load_en)
         q <= load_val;
      else if (shift_en)
         q <= {top_bit, q[W-1:1]};
   end
endmodule

// File: rtl/trap_prio.sv
// Fixed-priority selection among the configured sources.
module trap_prio
   import trap_pkg::*;
#(
   parameter bit EN_OVF  = 1'b1,
   parameter bit EN_RESV = 1'b1,
   parameter bit EN_CPU  = 1'b1,
   parameter bit EN_ADDR = 1'b1
) (
   input  logic              adel,
   input  logic              ades,
   input  logic              resv,
   input  logic              cpu,
   input  logic              ovf,
   input  logic              irq_live,
   output logic              take,
   output logic              addr_err,
   output logic [CODE_W-1:0] code
);
   logic adel_m, ades_m, resv_m, cpu_m, ovf_m;

   generate
      if (EN_ADDR) begin : g_addr
         assign adel_m = adel;
         assign ades_m = ades;
      end else begin : g_no_addr
         assign adel_m = 1'b0;
         assign ades_m = 1'b0;
      end
      if (EN_RESV) begin : g_resv
         assign resv_m = resv;
      end else begin : g_no_resv
         assign resv_m = 1'b0;
      end
      if (EN_CPU) begin : g_cpu
         assign cpu_m = cpu;
      end else begin : g_no_cpu
         assign cpu_m = 1'b0;
      end
      if (EN_OVF) begin : g_ovf
         assign ovf_m = ovf;
      end else begin : g_no_ovf
         assign ovf_m = 1'b0;
      end
   endgenerate

   always_comb begin
      take     = 1'b1;
      addr_err = 1'b0;
      code     = CODE_INT;
      if (adel_m) begin
         code     = CODE_ADEL;
         addr_err = 1'b1;
      end else if (ades_m) begin
         code     = CODE_ADES;
         addr_err = 1'b1;
      end else if (resv_m)
         code = CODE_RI;
      else if (cpu_m)
         code = CODE_CPU;
      else if (ovf_m)
         code = CODE_OV;
      else if (irq_live)
         code = CODE_INT;
      else
         take = 1'b0;
   end
endmodule

// File: rtl/trap_ctrl_serial.sv
module trap_ctrl_serial
   import trap_pkg::*;
#(
   parameter int          W       = 32,
   parameter logic [31:0] VECTOR  = 32'h0000_0080,
   parameter bit          EN_OVF  = 1'b1,
   parameter bit          EN_RESV = 1'b1,
   parameter bit          EN_CPU  = 1'b1,
   parameter bit          EN_ADDR = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         req_adel,
   input  logic         req_ades,
   input  logic         req_resv,
   input  logic         req_cpu,
   input  logic         req_ovf,
   input  logic         irq,
   input  logic         rfe_i,
   input  logic [W-1:0] pc_i,
   input  logic [W-1:0] badaddr_i,
   input  logic [1:0]   reg_sel,
   input  logic         shift_en,
   input  logic         wr_en,
   input  logic         wr_bit,
   output logic         rd_bit_o,
   output logic         redirect_o,
   output logic [W-1:0] vector_o
);
   localparam int CODE_MSB = CODE_LSB + CODE_W - 1;

   generate
      if (W < CODE_MSB + 1) begin : g_bad_width
         $error("trap_ctrl_serial: W too small for cause field");
      end
      if (W < 32 && (VECTOR >> W) != 0) begin : g_bad_vector
         $error("trap_ctrl_serial: VECTOR does not fit in W bits");
      end
   endgenerate

   reg_sel_e sel;
   assign sel = reg_sel_e'(reg_sel);

   logic [W-1:0] status_q, cause_q, epc_q, badaddr_q;
   logic         take, addr_err;
   logic [CODE_W-1:0] code;
   logic         redirect_q;

   trap_prio #(
      .EN_OVF (EN_OVF),
      .EN_RESV(EN_RESV),
      .EN_CPU (EN_CPU),
      .EN_ADDR(EN_ADDR)
   ) u_prio (
      .adel    (req_adel),
      .ades    (req_ades),
      .resv    (req_resv),
      .cpu     (req_cpu),
      .ovf     (req_ovf),
      .irq_live(irq & status_q[0]),
      .take    (take),
      .addr_err(addr_err),
      .code    (code)
   );

   // status: capture > serial shift > return-from-exception
   logic         sh_status, st_load;
   logic [W-1:0] st_val;
   assign sh_status = shift_en && (sel == SEL_STATUS);
   assign st_load   = take || (rfe_i && !sh_status);
   always_comb begin
      st_val = status_q;
      if (take) begin
         st_val[1] = status_q[0];
         st_val[0] = 1'b0;
      end else begin
         st_val[0] = status_q[1];
      end
   end

   trap_sreg #(.W(W), .WRITABLE(1'b1)) u_status (
      .clk(clk), .rst_n(rst_n),
      .load_en(st_load), .load_val(st_val),
      .shift_en(sh_status), .wr_en(wr_en), .wr_bit(wr_bit),
      .q(status_q)
   );

   logic [W-1:0] cause_val;
   always_comb begin
      cause_val = '0;
      cause_val[CODE_MSB:CODE_LSB] = code;
   end

   trap_sreg #(.W(W), .WRITABLE(1'b0)) u_cause (
      .clk(clk), .rst_n(rst_n),
      .load_en(take), .load_val(cause_val),
      .shift_en(shift_en && (sel == SEL_CAUSE)), .wr_en(wr_en), .wr_bit(wr_bit),
      .q(cause_q)
   );

   trap_sreg #(.W(W), .WRITABLE(1'b1)) u_epc (
      .clk(clk), .rst_n(rst_n),
      .load_en(take), .load_val(pc_i),
      .shift_en(shift_en && (sel == SEL_EPC)), .wr_en(wr_en), .wr_bit(wr_bit),
      .q(epc_q)
   );

   generate
      if (EN_ADDR) begin : g_badaddr
         trap_sreg #(.W(W), .WRITABLE(1'b0)) u_badaddr (
            .clk(clk), .rst_n(rst_n),
            .load_en(take && addr_err), .load_val(badaddr_i),
            .shift_en(shift_en && (sel == SEL_BADADDR)), .wr_en(wr_en), .wr_bit(wr_bit),
            .q(badaddr_q)
         );
      end else begin : g_no_badaddr
         assign badaddr_q = '0;
      end
   endgenerate

   always_comb begin
      unique case (sel)
         SEL_STATUS:  rd_bit_o = status_q[0];
         SEL_CAUSE:   rd_bit_o = cause_q[0];
         SEL_EPC:     rd_bit_o = epc_q[0];
         default:     rd_bit_o = badaddr_q[0];
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         redirect_q <= 1'b0;
      else
         redirect_q <= take;
   end

   assign redirect_o = redirect_q;
   assign vector_o   = VECTOR[W-1:0];
endmodule

// File: rtl/trap_ctrl_chk.sv
module trap_ctrl_chk #(
   parameter int W       = 32,
   parameter bit EN_OVF  = 1'b1,
   parameter bit EN_RESV = 1'b1,
   parameter bit EN_CPU  = 1'b1,
   parameter bit EN_ADDR = 1'b1
) (
   input logic         clk,
   input logic         rst_n,
   input logic         req_adel,
   input logic         req_ades,
   input logic         req_resv,
   input logic         req_cpu,
   input logic         req_ovf,
   input logic         irq,
   input logic         rfe_i,
   input logic [W-1:0] pc_i,
   input logic [1:0]   reg_sel,
   input logic         shift_en,
   input logic         redirect_o,
   input logic [W-1:0] status_q,
   input logic [W-1:0] cause_q,
   input logic [W-1:0] epc_q
);
   logic exc_req, exc_any;
   assign exc_req = (EN_ADDR && (req_adel || req_ades)) || (EN_RESV && req_resv)
                  || (EN_CPU && req_cpu) || (EN_OVF && req_ovf);
   assign exc_any = exc_req || (irq && status_q[0]);

   assert_redirect_R4: assert property (@(posedge clk) disable iff (!rst_n)
      exc_any |=> redirect_o);

   assert_no_redirect_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !exc_any |=> !redirect_o);

   assert_epc_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
      exc_any |=> epc_q == $past(pc_i));

   assert_adel_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (EN_ADDR && req_adel) |=> cause_q[6:2] == 5'd4);

   assert_ie_saved_R8: assert property (@(posedge clk) disable iff (!rst_n)
      exc_any |=> (!status_q[0] && status_q[1] == $past(status_q[0])));

   assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !status_q[0] && !exc_req) |=> !redirect_o);

   assert_rfe_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rfe_i && !exc_any && !(shift_en && reg_sel == 2'd0))
         |=> status_q[0] == $past(status_q[1]));
endmodule

bind trap_ctrl_serial trap_ctrl_chk #(
   .W(W), .EN_OVF(EN_OVF), .EN_RESV(EN_RESV), .EN_CPU(EN_CPU), .EN_ADDR(EN_ADDR)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .req_adel(req_adel), .req_ades(req_ades), .req_resv(req_resv),
   .req_cpu(req_cpu), .req_ovf(req_ovf), .irq(irq), .rfe_i(rfe_i),
   .pc_i(pc_i), .reg_sel(reg_sel), .shift_en(shift_en),
   .redirect_o(redirect_o),
   .status_q(status_q), .cause_q(cause_q), .epc_q(epc_q)
);

// File: tb/trap_ctrl_serial_bench.sv
`timescale 1ns/1ps
module trap_ctrl_serial_bench;
   localparam int W = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_adel = 0, req_ades = 0, req_resv = 0, req_cpu = 0, req_ovf = 0;
   logic irq = 0, rfe_i = 0;
   logic [W-1:0] pc_i = '0, badaddr_i = '0;
   logic [1:0] reg_sel = 2'd0;
   logic shift_en = 0, wr_en = 0, wr_bit = 0;
   logic rd_bit_o, redirect_o;
   logic [W-1:0] vector_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #5 clk = ~clk;

   trap_ctrl_serial u_trap_ctrl_serial (
      .clk(clk), .rst_n(rst_n),
      .req_adel(req_adel), .req_ades(req_ades), .req_resv(req_resv),
      .req_cpu(req_cpu), .req_ovf(req_ovf), .irq(irq), .rfe_i(rfe_i),
      .pc_i(pc_i), .badaddr_i(badaddr_i),
      .reg_sel(reg_sel), .shift_en(shift_en), .wr_en(wr_en), .wr_bit(wr_bit),
      .rd_bit_o(rd_bit_o), .redirect_o(redirect_o), .vector_o(vector_o)
   );

   task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic rd(input logic [1:0] s, output logic [W-1:0] v);
      v = '0;
      for (int i = 0; i < W; i++) begin
         @(negedge clk);
         reg_sel = s; shift_en = 1; wr_en = 0;
         #1 v[i] = rd_bit_o;
      end
      @(negedge clk);
      shift_en = 0;
   endtask

   task automatic wr(input logic [1:0] s, input logic [W-1:0] v);
      for (int i = 0; i < W; i++) begin
         @(negedge clk);
         reg_sel = s; shift_en = 1; wr_en = 1; wr_bit = v[i];
      end
      @(negedge clk);
      shift_en = 0; wr_en = 0;
   endtask

   // expected cause code from the requirements (R6, R7, R9); -1 when nothing is taken
   function automatic int exp_code(logic [5:0] r, logic ie);
      if (r[0]) return 4;
      if (r[1]) return 5;
      if (r[2]) return 10;
      if (r[3]) return 11;
      if (r[4]) return 12;
      if (r[5] && ie) return 0;
      return -1;
   endfunction

   task automatic pulse(input logic [5:0] r, input logic [W-1:0] pc, input logic [W-1:0] ba);
      @(negedge clk);
      {irq, req_ovf, req_cpu, req_resv, req_ades, req_adel} = r;
      pc_i = pc; badaddr_i = ba;
      @(negedge clk);
      {irq, req_ovf, req_cpu, req_resv, req_ades, req_adel} = '0;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] v, m_epc, m_bad, pc, ba;
      logic [5:0] r;
      int c;
      void'($urandom(32'h5eed));
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R1 reset state
      chk("R1 redirect", {31'b0, redirect_o}, '0);
      for (int s = 0; s < 4; s++) begin
         rd(s[1:0], v);
         chk("R1 reg", v, '0);
      end

      // R9 masked interrupt
      pulse(6'b100000, 32'h1111_0000, 32'h0);
      chk("R9 no redirect", {31'b0, redirect_o}, '0);
      rd(2'd2, v); chk("R9 epc untouched", v, '0);

      // R2 write status, read back
      wr(2'd0, 32'hA5A5_0001);
      rd(2'd0, v); chk("R2 status write", v, 32'hA5A5_0001);
      rd(2'd0, v); chk("R2 read non-destructive", v, 32'hA5A5_0001);

      // R3 cause read-only
      wr(2'd1, 32'hFFFF_FFFF);
      rd(2'd1, v); chk("R3 cause read-only", v, '0);

      // R4 R5 R6 R8 interrupt taken
      pulse(6'b100000, 32'h0000_4444, 32'h0);
      chk("R4 redirect", {31'b0, redirect_o}, 32'd1);
      chk("R4 vector", vector_o, 32'h80);
      @(negedge clk);
      chk("R4 one cycle", {31'b0, redirect_o}, '0);
      rd(2'd2, v); chk("R5 epc", v, 32'h0000_4444);
      rd(2'd1, v); chk("R6 int code", v, '0);
      rd(2'd0, v); chk("R8 status saved", v, 32'hA5A5_0002);
      rd(2'd3, v); chk("R11 badaddr untouched", v, '0);

      // R10 return from exception
      @(negedge clk); rfe_i = 1;
      @(negedge clk); rfe_i = 0;
      rd(2'd0, v); chk("R10 rfe", v, 32'hA5A5_0003);

      // R12 capture beats serial read of epc
      wr(2'd0, 32'h1);
      for (int i = 0; i < 10; i++) begin
         @(negedge clk); reg_sel = 2'd2; shift_en = 1; wr_en = 0;
      end
      @(negedge clk); req_ovf = 1; pc_i = 32'hCAFE_0123;
      @(negedge clk); req_ovf = 0; shift_en = 0;
      chk("R12 redirect", {31'b0, redirect_o}, 32'd1);
      rd(2'd2, v); chk("R12 epc after shift collision", v, 32'hCAFE_0123);
      rd(2'd1, v); chk("R12 ovf code", v, 32'd12 << 2);

      // R12 capture beats rfe
      wr(2'd0, 32'h1);
      @(negedge clk); rfe_i = 1; req_resv = 1; pc_i = 32'h10;
      @(negedge clk); rfe_i = 0; req_resv = 0;
      rd(2'd0, v); chk("R12 status take over rfe", v, 32'h2);

      // R11 address error on store
      pulse(6'b000010, 32'h20, 32'hDEAD_BEEF);
      rd(2'd3, v); chk("R11 badaddr", v, 32'hDEAD_BEEF);
      rd(2'd1, v); chk("R6 ades code", v, 32'd5 << 2);
      m_epc = 32'h20; m_bad = 32'hDEAD_BEEF;

      // R7 random mixes
      for (int it = 0; it < 40; it++) begin
         wr(2'd0, 32'h1);
         r  = 6'($urandom);
         if (it < 4) r = 6'b111111 >> it;
         pc = $urandom; ba = $urandom;
         c  = exp_code(r, 1'b1);
         pulse(r, pc, ba);
         chk("R7 redirect", {31'b0, redirect_o}, (c >= 0) ? 32'd1 : 32'd0);
         if (c >= 0) begin
            m_epc = pc;
            if (c == 4 || c == 5) m_bad = ba;
         end
         rd(2'd1, v);
         if (c >= 0) chk("R7 cause", v, 32'(c) << 2);
         rd(2'd2, v); chk("R5 epc random", v, m_epc);
         rd(2'd3, v); chk("R11 badaddr random", v, m_bad);
         rd(2'd0, v); chk("R8 status random", v, (c >= 0) ? 32'h2 : 32'h1);
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule